// File: doc/BRIEF.md
# MII Transmit Engine with Deferral

This block turns a byte stream into an Ethernet frame on a nibble-wide media-independent interface. The source presents bytes with a valid/ready handshake and marks the first byte, the last byte and any byte that carries an error. The engine puts seven 0x55 bytes and the 0xD5 delimiter in front of the frame, follows the payload with a CRC-32 frame check sequence, and drives TXD and TX_EN from the transmit clock that the PHY supplies.

Each frame waits for the inter-packet gap before it starts. The gap length comes from an input that software programs. In half duplex, carrier or receive activity delays a waiting frame, and the gap is counted from the cycle in which both the line and this transmitter go quiet. In full duplex, receive activity is ignored and the gap is counted from the end of this block's own transmission. The engine has no transmit-error pin. An error flagged during a frame, or a source that runs dry in the middle of a frame, ends that frame with the complement of the correct check sequence. Every output is registered and all logic runs on the one TX_CLK domain, so the engine works at 25 MHz or 2.5 MHz, and it holds its state when the clock is stretched or stopped.

Top module: `mii_tx_engine`

## Requirements
- R1: After reset, tx_en is 0 and txd is 0. A frame offered right after reset does not wait for a gap: tx_en rises on the second clock edge after the first byte with in_sof is presented.
- R2: tx_en stays high for the whole frame. The frame opens with fifteen 0x5 nibbles and then one 0xD nibble, which is seven 0x55 bytes and a 0xD5 byte sent low nibble first.
- R3: Payload bytes follow the delimiter in order, one byte every two clock cycles, with bits 3:0 sent before bits 7:4. A byte is taken when in_valid and in_ready are both high at a clock edge. During a frame, in_ready is high only in the cycle just before a byte's low nibble is due.
- R4: Four FCS bytes follow the payload. They are the complement of a CRC-32 over the payload. The CRC uses polynomial 0x04C11DB7 in bit-reversed form (0xEDB88320), starts from all ones and shifts in each byte least significant bit first. The FCS value goes out bits 3:0 first. tx_en falls right after the last FCS nibble, so a frame of n bytes is 2*(n+12) nibbles long.
- R5: If in_err is high on any byte taken during a frame, the frame still runs to its end, and its four FCS bytes are the bitwise inverse of the R4 value.
- R6: If in_valid is low in a cycle where a payload byte is due, the frame ends at once. The FCS goes out next, over the bytes taken so far and inverted as in R5.
- R7: While the engine is idle, a byte with in_valid high and in_sof low is taken (in_ready is high) and dropped. No transmission results.
- R8: When the next frame is already waiting, tx_en stays low for exactly ipg_cycles clock cycles between frames (ipg_cycles at least 2), in either duplex mode, while crs and rx_dv are low.
- R9: In full duplex (full_duplex = 1), crs and rx_dv have no effect. A frame starts while they are high, and the gap between back-to-back frames is still exactly ipg_cycles.
- R10: In half duplex (full_duplex = 0), crs or rx_dv held high keeps a waiting frame from starting. tx_en then rises on the ipg_cycles-th clock edge at which both inputs are sampled low.

Full-duplex mode is latched only while the engine is idle. A change made during a frame takes effect after that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock from the PHY |
| rst | input | 1 | Synchronous reset, active high |
| full_duplex | input | 1 | 1 selects full duplex, 0 selects half duplex |
| ipg_cycles | input | IPG_W | Inter-packet gap in clock cycles |
| in_valid | input | 1 | Source byte is present |
| in_ready | output | 1 | Engine takes the byte at this edge |
| in_data | input | 8 | Source byte |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_err | input | 1 | Byte carries an error; the frame gets a bad FCS |
| crs | input | 1 | Carrier sense from the PHY |
| rx_dv | input | 1 | Receive data valid from the PHY |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit nibbles are valid |

## Verification
Frames are sent with lengths of 1, 5, 10, 46 and 60 bytes, in both duplex modes, with clean payloads, with an error on a middle byte and with an error on the last byte. This shows whether framing and the CRC cover every byte, and whether the error inversion is keyed to the flag and not to the byte's position. Back-to-back pairs are sent in full duplex with carrier and receive activity held high and in half duplex with them low, and the gap must equal the programmed length in both cases. A pair with a shorter programmed gap confirms that the register really sets the length. A frame held back by receive activity in half duplex shows that the hold-off and the restart count are separate from the gap measured after the block's own transmission. An underrun frame and a stray byte without a start flag complete the set.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PRE,
    ST_DATA,
    ST_FCS
  } tx_state_e;

  localparam logic [31:0] CRC_POLY_REV = 32'hEDB88320;
  localparam logic [31:0] CRC_PRESET   = 32'hFFFFFFFF;

  // Advance a bit-reversed CRC-32 by one byte, least significant bit first.
  function automatic logic [31:0] crc32_step(input logic [31:0] c_in, input logic [7:0] d);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[0] ^ d[b];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REV;
    end
    return c;
  endfunction

endpackage

// File: rtl/mii_crc32.sv
module mii_crc32
  import mii_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        init,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || init) crc_q <= CRC_PRESET;
    else if (en)     crc_q <= crc32_step(crc_q, din);
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/mii_tx_defer.sv
module mii_tx_defer #(
  parameter int IPG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en_i,
  input  logic             crs_i,
  input  logic             rx_dv_i,
  input  logic             full_i,
  input  logic [IPG_W-1:0] ipg_i,
  output logic             may_start_o
);

  localparam logic [IPG_W-1:0] CNT_MAX = '1;
  localparam logic [IPG_W:0]   LEAD    = (IPG_W+1)'(2);

  logic [IPG_W-1:0] quiet_q;
  logic             carrier;
  logic             busy;
  logic [IPG_W:0]   elapsed;

  // Receive activity counts only in half duplex.
  assign carrier = !full_i && (crs_i || rx_dv_i);
  assign busy    = tx_en_i || carrier;

  // Quiet cycles counted since the line and the transmitter both went idle.
  // The count saturates, so after reset the first frame goes out at once.
  always_ff @(posedge clk) begin
    if (rst)                       quiet_q <= CNT_MAX;
    else if (busy)                 quiet_q <= '0;
    else if (quiet_q != CNT_MAX)   quiet_q <= quiet_q + IPG_W'(1);
  end

  // The +2 covers the edge at which the start is decided and the edge that raises tx_en.
  assign elapsed     = {1'b0, quiet_q} + LEAD;
  assign may_start_o = !busy && (elapsed >= {1'b0, ipg_i});

  // R10: in half duplex no frame starts from an edge that saw carrier or receive activity.
  assert_half_defer_R10: assert property (@(posedge clk) disable iff (rst)
    (!full_i && $rose(tx_en_i)) |-> !$past(crs_i || rx_dv_i, 2));

endmodule

// File: rtl/mii_tx_engine.sv
module mii_tx_engine
  import mii_tx_pkg::*;
#(
  parameter int IPG_W     = 8,
  parameter int PRE_BYTES = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             full_duplex,
  input  logic [IPG_W-1:0] ipg_cycles,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_err,
  input  logic             crs,
  input  logic             rx_dv,
  output logic [3:0]       txd,
  output logic             tx_en
);

  localparam int PRE_NIB = 2 * PRE_BYTES + 2;
  localparam int FCS_NIB = 8;
  localparam int CNT_W   = $clog2(PRE_NIB + 1);
  localparam int MIN_NIB = PRE_NIB + FCS_NIB;
  localparam int RUN_W   = 16;
  localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIB - 1);
  localparam logic [CNT_W-1:0] FCS_LAST = CNT_W'(FCS_NIB - 1);

  tx_state_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             half_q, last_q, err_q, mode_q;
  logic [3:0]       hi_q, txd_q;
  logic             tx_en_q;
  logic             may_start, start, take;
  logic [31:0]      crc_q, fcs_word;

  assign start    = (st_q == ST_IDLE) && in_valid && in_sof && may_start;
  assign in_ready = ((st_q == ST_IDLE) && !in_sof) || ((st_q == ST_DATA) && !half_q);
  assign take     = (st_q == ST_DATA) && !half_q && in_valid;
  assign fcs_word = err_q ? crc_q : ~crc_q;

  mii_crc32 u_crc (
    .clk   (clk),
    .rst   (rst),
    .init  (start),
    .en    (take),
    .din   (in_data),
    .crc_o (crc_q)
  );

  mii_tx_defer #(.IPG_W(IPG_W)) u_defer (
    .clk         (clk),
    .rst         (rst),
    .tx_en_i     (tx_en_q),
    .crs_i       (crs),
    .rx_dv_i     (rx_dv),
    .full_i      (mode_q),
    .ipg_i       (ipg_cycles),
    .may_start_o (may_start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      half_q  <= 1'b0;
      last_q  <= 1'b0;
      err_q   <= 1'b0;
      mode_q  <= 1'b0;
      hi_q    <= '0;
      txd_q   <= '0;
      tx_en_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          tx_en_q <= 1'b0;
          txd_q   <= '0;
          if (start) begin
            st_q   <= ST_PRE;
            cnt_q  <= '0;
            err_q  <= 1'b0;
            half_q <= 1'b0;
          end else begin
            mode_q <= full_duplex;
          end
        end
        ST_PRE: begin
          tx_en_q <= 1'b1;
          txd_q   <= (cnt_q == PRE_LAST) ? 4'hD : 4'h5;
          if (cnt_q == PRE_LAST) begin
            st_q   <= ST_DATA;
            half_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_DATA: begin
          tx_en_q <= 1'b1;
          if (!half_q) begin
            if (in_valid) begin
              txd_q  <= in_data[3:0];
              hi_q   <= in_data[7:4];
              last_q <= in_eof;
              err_q  <= err_q | in_err;
              half_q <= 1'b1;
            end else begin
              // Source ran dry: close the frame with a corrupted check sequence.
              txd_q <= crc_q[3:0];
              err_q <= 1'b1;
              cnt_q <= CNT_W'(1);
              st_q  <= ST_FCS;
            end
          end else begin
            txd_q  <= hi_q;
            half_q <= 1'b0;
            if (last_q) begin
              st_q  <= ST_FCS;
              cnt_q <= '0;
            end
          end
        end
        ST_FCS: begin
          tx_en_q <= 1'b1;
          txd_q   <= fcs_word[{cnt_q[2:0], 2'b00} +: 4];
          if (cnt_q == FCS_LAST) st_q  <= ST_IDLE;
          else                   cnt_q <= cnt_q + CNT_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign txd   = txd_q;
  assign tx_en = tx_en_q;

  // Run-length counters that feed the assertions below.
  logic [RUN_W-1:0] nib_run;
  logic [IPG_W-1:0] low_run;
  logic             seen_frame;

  always_ff @(posedge clk) begin
    if (rst) begin
      nib_run    <= '0;
      low_run    <= '0;
      seen_frame <= 1'b0;
    end else if (tx_en_q) begin
      if (nib_run != '1) nib_run <= nib_run + RUN_W'(1);
      low_run    <= '0;
      seen_frame <= 1'b1;
    end else begin
      nib_run <= '0;
      if (low_run != '1) low_run <= low_run + IPG_W'(1);
    end
  end

  // R2: every frame opens with a preamble nibble.
  assert_preamble_first_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_en) |-> (txd == 4'h5));

  // R4: a frame holds at least preamble, delimiter and FCS, in whole bytes.
  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |-> ((nib_run >= RUN_W'(MIN_NIB)) && !nib_run[0]));

  // R8: tx_en never rises again before the programmed gap has passed.
  assert_gap_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(tx_en) && seen_frame) |-> (low_run >= ipg_cycles));

endmodule

// File: tb/mii_tx_engine_bench.sv
module mii_tx_engine_bench;

  localparam int IPG_W = 8;
  localparam int NVEC  = 5;
  // {full_duplex, length, seed, error byte index (FF = none)}
  localparam logic [24:0] VEC [0:NVEC-1] = '{
    {1'b1, 8'd1,  8'h03, 8'hFF},
    {1'b0, 8'd46, 8'h09, 8'hFF},
    {1'b1, 8'd5,  8'h20, 8'd2},
    {1'b0, 8'd10, 8'h44, 8'd9},
    {1'b1, 8'd60, 8'h77, 8'hFF}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic             full_duplex = 1'b0;
  logic [IPG_W-1:0] ipg_cycles  = 8'd24;
  logic             in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0, in_err = 1'b0;
  logic [7:0]       in_data  = '0;
  logic             crs = 1'b0, rx_dv = 1'b0;
  logic             in_ready;
  logic [3:0]       txd;
  logic             tx_en;

  mii_tx_engine #(.IPG_W(IPG_W)) u_mii_tx_engine (
    .clk(clk), .rst(rst), .full_duplex(full_duplex), .ipg_cycles(ipg_cycles),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
    .crs(crs), .rx_dv(rx_dv), .txd(txd), .tx_en(tx_en)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Line monitor: rebuilds bytes and measures gaps, sampling at the falling edge.
  logic [7:0] mbyte [0:15][0:79];
  int   mnib [0:15];
  int   mgap [0:15];
  int   nfr = 0, lowrun = 0, curn = 0;
  bit   prev_en = 1'b0;
  logic [3:0] lo_nib = '0;

  always @(negedge clk) begin
    if (!rst && nfr < 16) begin
      if (tx_en) begin
        if (!prev_en) begin mgap[nfr] = lowrun; curn = 0; end
        if (curn % 2 == 0) lo_nib = txd;
        else if (curn / 2 < 80) mbyte[nfr][curn/2] = {txd, lo_nib};
        curn++;
      end else begin
        if (prev_en) begin mnib[nfr] = curn; nfr++; lowrun = 0; end
        lowrun++;
      end
      prev_en = tx_en;
    end
  end

  function automatic logic [7:0] pay(input int seed, input int i);
    return 8'((seed * 7 + i * 29 + 5) & 255);
  endfunction

  function automatic logic [31:0] raw_crc(input int seed, input int n);
    logic [31:0] c = 32'hFFFFFFFF;
    logic [7:0]  d;
    logic        fb;
    for (int i = 0; i < n; i++) begin
      d = pay(seed, i);
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ d[b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return c;
  endfunction

  task automatic send_frame(input int seed, input int n, input int eidx, input bit no_eof);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1;
      in_data  = pay(seed, i);
      in_sof   = (i == 0);
      in_eof   = (i == n - 1) && !no_eof;
      in_err   = (i == eidx);
      forever begin
        #1;
        if (in_ready) break;
        @(negedge clk);
      end
      @(posedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_err = 1'b0;
  endtask

  task automatic wait_idle();
    int q = 0;
    while (q < 60) begin
      @(negedge clk);
      if (tx_en) q = 0; else q++;
    end
  endtask

  task automatic check_frame(input int idx, input int seed, input int n, input bit bad);
    bit pre_ok = 1'b1, pay_ok = 1'b1;
    logic [31:0] exp_fcs, got;
    chk(mnib[idx] == 2 * (n + 12), "R4 nibble count", mnib[idx], 2 * (n + 12));
    for (int k = 0; k < 7; k++) if (mbyte[idx][k] != 8'h55) pre_ok = 1'b0;
    if (mbyte[idx][7] != 8'hD5) pre_ok = 1'b0;
    chk(pre_ok, "R2 preamble and delimiter", mbyte[idx][7], 8'hD5);
    for (int k = 0; k < n; k++) if (mbyte[idx][8+k] != pay(seed, k)) pay_ok = 1'b0;
    chk(pay_ok, "R3 payload order", idx, n);
    exp_fcs = bad ? raw_crc(seed, n) : ~raw_crc(seed, n);
    got = {mbyte[idx][8+n+3], mbyte[idx][8+n+2], mbyte[idx][8+n+1], mbyte[idx][8+n]};
    if (bad) chk(got == exp_fcs, "R5 inverted FCS", got, exp_fcs);
    else     chk(got == exp_fcs, "R4 FCS value", got, exp_fcs);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base, k, seed, n, eidx;
    bit any_tx;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(tx_en == 1'b0 && txd == 4'h0, "R1 reset outputs", {tx_en, txd}, 0);

    // R1: first frame after reset starts without a gap
    base = nfr;
    k = 0;
    fork
      send_frame(8'h31, 3, 8'hFF, 1'b0);
      begin
        do begin @(negedge clk); k++; end while (!tx_en && k < 100);
        chk(k == 2, "R1 start latency", k, 2);
      end
    join
    wait_idle();
    check_frame(base, 8'h31, 3, 1'b0);

    // Table of frames
    for (int v = 0; v < NVEC; v++) begin
      full_duplex = VEC[v][24];
      n    = int'(VEC[v][23:16]);
      seed = int'(VEC[v][15:8]);
      eidx = (VEC[v][7:0] == 8'hFF) ? -1 : int'(VEC[v][7:0]);
      repeat (3) @(negedge clk);
      base = nfr;
      send_frame(seed, n, eidx, 1'b0);
      wait_idle();
      chk(nfr == base + 1, "R3 one frame per vector", nfr - base, 1);
      check_frame(base, seed, n, eidx >= 0);
    end

    // R7: stray byte without start flag is dropped
    @(negedge clk);
    base = nfr;
    in_valid = 1'b1; in_sof = 1'b0; in_data = 8'hAB;
    #1 chk(in_ready == 1'b1, "R7 stray byte taken", in_ready, 1);
    any_tx = 1'b0;
    repeat (40) begin @(negedge clk); if (tx_en) any_tx = 1'b1; end
    in_valid = 1'b0;
    chk(!any_tx && nfr == base, "R7 no transmission", any_tx, 0);

    // R9: full duplex ignores carrier and receive activity, gap still exact
    full_duplex = 1'b1; crs = 1'b1; rx_dv = 1'b1;
    repeat (3) @(negedge clk);
    base = nfr;
    send_frame(8'h51, 8, -1, 1'b0);
    send_frame(8'h52, 12, -1, 1'b0);
    wait_idle();
    chk(nfr == base + 2, "R9 frames sent under carrier", nfr - base, 2);
    chk(mgap[base+1] == 24, "R9 gap under carrier", mgap[base+1], 24);
    check_frame(base + 1, 8'h52, 12, 1'b0);
    crs = 1'b0; rx_dv = 1'b0;

    // R8: half duplex back-to-back gap
    full_duplex = 1'b0;
    repeat (3) @(negedge clk);
    base = nfr;
    send_frame(8'h61, 6, -1, 1'b0);
    send_frame(8'h62, 7, -1, 1'b0);
    wait_idle();
    chk(mgap[base+1] == 24, "R8 half duplex gap", mgap[base+1], 24);

    // R8: a shorter programmed gap
    full_duplex = 1'b1; ipg_cycles = 8'd8;
    repeat (3) @(negedge clk);
    base = nfr;
    send_frame(8'h71, 4, -1, 1'b0);
    send_frame(8'h72, 4, -1, 1'b0);
    wait_idle();
    chk(mgap[base+1] == 8, "R8 short gap", mgap[base+1], 8);
    ipg_cycles = 8'd24;

    // R10: half duplex holds a waiting frame while receive is active
    full_duplex = 1'b0;
    @(negedge clk);
    rx_dv = 1'b1;
    repeat (3) @(negedge clk);
    base = nfr;
    k = 0;
    fork
      send_frame(8'h81, 9, -1, 1'b0);
      begin
        repeat (50) @(negedge clk);
        chk(nfr == base && !tx_en, "R10 held by receive", tx_en, 0);
        chk(in_ready == 1'b0, "R3 ready low while held", in_ready, 0);
        rx_dv = 1'b0;
        do begin @(negedge clk); k++; end while (!tx_en && k < 200);
        chk(k == 24, "R10 restart delay", k, 24);
      end
    join
    wait_idle();
    check_frame(base, 8'h81, 9, 1'b0);

    // R6: source underrun closes the frame with a bad FCS
    repeat (3) @(negedge clk);
    base = nfr;
    send_frame(8'h91, 4, -1, 1'b1);
    wait_idle();
    chk(nfr == base + 1, "R6 underrun frame ends", nfr - base, 1);
    check_frame(base, 8'h91, 4, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule